// File: doc/BRIEF.md
# Vector-Programmed Transmit Word Unpacker

This block sits between a transmit FIFO of 32-bit entries and a serial shifter. It takes one FIFO word at a time over a valid/ready handshake and emits its bits one per handshake on a serial output. The bits it sends, and their order, come from four runtime-loaded 10-bit extraction vectors. Each vector names a start bit, a walking direction, a run length of one to eight bits and a stop flag. Vectors run in order until one with the stop flag completes, and then the word is finished. The same datapath can therefore serve any character width, any number of characters per FIFO entry and either bit order.

The sequencer has two states. In `ST_IDLE` it asserts `word_ready`. The transition `ST_IDLE -> ST_SHIFT` happens when `word_valid` is seen; it captures the word and freezes a working copy of the vectors. In `ST_SHIFT` it presents one bit per cycle and advances only on `bit_ready`. The transition `ST_SHIFT -> ST_IDLE` happens on the handshake of the bit flagged `bit_last`. Software loads all four vectors at once through `cfg_lo` and `cfg_hi` with a single `cfg_we` strobe.

Top module: `tx_vec_unpacker`

## Requirements
- R1: After reset `word_ready` is 1 and `bit_valid` is 0. The vectors hold a default of four 8-bit runs sent LSB-first, starting at bits 0, 8, 16 and 24, with the stop flag on vector 3.
- R2: A vector's bit 9 is the stop flag, bits 8:6 the length code, bit 5 the direction and bits 4:0 the start index. `cfg_lo[9:0]` is vector 0, `cfg_lo[19:10]` vector 1, `cfg_hi[9:0]` vector 2 and `cfg_hi[19:10]` vector 3. All four are written on a cycle with `cfg_we` high.
- R3: A vector moves exactly (length code + 1) bits.
- R4: Direction 1 sends bit start, start-1, and so on downward. Direction 0 sends start, start+1, and so on upward. The index wraps modulo 32.
- R5: Vectors are used in order from 0. The first vector with its stop flag set is the last one used for the word, and later vectors have no effect on the output.
- R6: If no vector from 0 to 2 carries the stop flag, vector 3 is the last one used, whatever its own flag.
- R7: While `bit_valid` is 1 and `bit_ready` is 0, `bit_data` and `bit_last` stay unchanged. No bit is skipped or repeated.
- R8: `word_ready` is 1 only when no word is in flight. A word accepted at a clock edge makes `bit_valid` 1 from the next cycle. After the last bit's handshake, `word_ready` is 1 for at least one cycle.
- R9: `bit_last` is 1 on exactly the final bit of each word.
- R10: A vector write during a word does not change that word's bits. A write in the same cycle as an acceptance takes effect from the following word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load all four vectors |
| cfg_lo | input | 20 | Vectors 1 (upper) and 0 (lower) |
| cfg_hi | input | 20 | Vectors 3 (upper) and 2 (lower) |
| word_valid | input | 1 | FIFO word offered |
| word_data | input | 32 | FIFO word |
| word_ready | output | 1 | Block can take a word |
| bit_valid | output | 1 | Serial bit present |
| bit_data | output | 1 | Serial bit |
| bit_last | output | 1 | Final bit of the current word |
| bit_ready | input | 1 | Downstream takes the bit |

## Verification
A word taken at an edge shows its first bit in the very next cycle. Each following bit appears one cycle after a handshake. `word_ready` returns in the cycle after the last bit's handshake, so a word of N bits occupies at least N+1 cycles. The bench keeps a behavioural model that is updated at each rising edge from the inputs seen there: it builds a queue of expected bits when a word is accepted and pops the queue on every handshake. It compares all four outputs against this model on every falling edge, midway between the edges where the results become due. It also covers random backpressure, writes to the vectors in the middle of a word and writes in the same cycle as an acceptance.

// File: rtl/tvu_pkg.sv
package tvu_pkg;

    localparam int WORD_W  = 32;
    localparam int IDX_W   = $clog2(WORD_W);
    localparam int LEN_W   = 3;
    localparam int NUM_VEC = 4;
    localparam int VEC_W   = 1 + LEN_W + 1 + IDX_W;
    localparam int VIDX_W  = $clog2(NUM_VEC);

    typedef struct packed {
        logic             stop;
        logic [LEN_W-1:0] len;
        logic             dir;
        logic [IDX_W-1:0] start;
    } vec_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } tvu_state_t;

    function automatic vec_t default_vec(input int i);
        vec_t v;
        v.stop  = (i == NUM_VEC - 1);
        v.len   = LEN_W'((1 << LEN_W) - 1);
        v.dir   = 1'b0;
        v.start = IDX_W'(i * (1 << LEN_W));
        return v;
    endfunction

endpackage

// File: rtl/tvu_cfg_bank.sv
module tvu_cfg_bank
    import tvu_pkg::*;
#(
    parameter int NV = NUM_VEC
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [2*VEC_W-1:0]     cfg_lo,
    input  logic [2*VEC_W-1:0]     cfg_hi,
    input  logic                   snap_en,
    output vec_t [NV-1:0]          act_vec
);

    vec_t [NV-1:0] prog_vec;
    vec_t [NV-1:0] wr_vec;

    for (genvar g = 0; g < NV; g++) begin : g_vec
        if (g < 2) begin : g_lo
            assign wr_vec[g] = vec_t'(cfg_lo[(g % 2)*VEC_W +: VEC_W]);
        end else begin : g_hi
            assign wr_vec[g] = vec_t'(cfg_hi[(g % 2)*VEC_W +: VEC_W]);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prog_vec[g] <= default_vec(g);
            end else if (cfg_we) begin
                prog_vec[g] <= wr_vec[g];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_vec[g] <= default_vec(g);
            end else if (snap_en) begin
                act_vec[g] <= prog_vec[g];
            end
        end
    end

endmodule

// File: rtl/tvu_bit_pick.sv
module tvu_bit_pick
    import tvu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  vec_t              vec,
    input  logic [LEN_W-1:0]  step,
    output logic              bit_out
);

    logic [IDX_W-1:0] idx;

    always_comb begin
        if (vec.dir) begin
            idx = vec.start - IDX_W'(step);
        end else begin
            idx = vec.start + IDX_W'(step);
        end
        bit_out = word[idx];
    end

endmodule

// File: rtl/tvu_seq.sv
module tvu_seq
    import tvu_pkg::*;
#(
    parameter int NV = NUM_VEC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_valid,
    input  logic [WORD_W-1:0]   word_data,
    output logic                word_ready,
    input  logic                bit_ready,
    output logic                bit_valid,
    output logic                bit_last,
    input  vec_t [NV-1:0]       act_vec,
    output logic                snap_en,
    output logic [WORD_W-1:0]   word_q,
    output vec_t                cur_vec,
    output logic [LEN_W-1:0]    bit_cnt
);

    localparam int VW = $clog2(NV);

    tvu_state_t      state, state_nx;
    logic [VW-1:0]   vec_idx;
    logic            accept, fire, at_len, final_vec;

    assign cur_vec   = act_vec[vec_idx];
    assign at_len    = (bit_cnt == cur_vec.len);
    assign final_vec = cur_vec.stop || (vec_idx == VW'(NV - 1));
    assign accept    = (state == ST_IDLE) && word_valid;
    assign fire      = (state == ST_SHIFT) && bit_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (word_valid)                  state_nx = ST_SHIFT;
            ST_SHIFT: if (bit_ready && at_len && final_vec) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // word capture and walk counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            vec_idx <= '0;
            bit_cnt <= '0;
        end else if (accept) begin
            word_q  <= word_data;
            vec_idx <= '0;
            bit_cnt <= '0;
        end else if (fire) begin
            if (at_len) begin
                bit_cnt <= '0;
                if (!final_vec) begin
                    vec_idx <= vec_idx + 1'b1;
                end
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        word_ready = 1'b0;
        bit_valid  = 1'b0;
        bit_last   = 1'b0;
        snap_en    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                word_ready = 1'b1;
                snap_en    = word_valid;
            end
            ST_SHIFT: begin
                bit_valid = 1'b1;
                bit_last  = at_len && final_vec;
            end
            default: ;
        endcase
    end

    p_accept_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && word_ready |=> bit_valid && !word_ready);

    p_cnt_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> bit_cnt <= cur_vec.len);

    p_no_walk_past_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid && vec_idx != '0 |-> !act_vec[vec_idx - 1'b1].stop);

    p_frozen_vectors_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid && !(bit_ready && bit_last) |=> $stable(act_vec));

endmodule

// File: rtl/tx_vec_unpacker.sv
module tx_vec_unpacker
    import tvu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2*VEC_W-1:0]   cfg_lo,
    input  logic [2*VEC_W-1:0]   cfg_hi,
    input  logic                 word_valid,
    input  logic [WORD_W-1:0]    word_data,
    output logic                 word_ready,
    output logic                 bit_valid,
    output logic                 bit_data,
    output logic                 bit_last,
    input  logic                 bit_ready
);

    vec_t [NUM_VEC-1:0] act_vec;
    vec_t               cur_vec;
    logic               snap_en;
    logic [WORD_W-1:0]  word_q;
    logic [LEN_W-1:0]   bit_cnt;

    tvu_cfg_bank #(.NV(NUM_VEC)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_lo  (cfg_lo),
        .cfg_hi  (cfg_hi),
        .snap_en (snap_en),
        .act_vec (act_vec)
    );

    tvu_seq #(.NV(NUM_VEC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ready (word_ready),
        .bit_ready  (bit_ready),
        .bit_valid  (bit_valid),
        .bit_last   (bit_last),
        .act_vec    (act_vec),
        .snap_en    (snap_en),
        .word_q     (word_q),
        .cur_vec    (cur_vec),
        .bit_cnt    (bit_cnt)
    );

    tvu_bit_pick u_pick (
        .word    (word_q),
        .vec     (cur_vec),
        .step    (bit_cnt),
        .bit_out (bit_data)
    );

    p_hold_under_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid && !bit_ready |=> bit_valid && $stable(bit_data) && $stable(bit_last));

    p_last_frees_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid && bit_ready && bit_last |=> word_ready && !bit_valid);

    p_exclusive_sides_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_ready && bit_valid));

endmodule

// File: tb/tb_tx_vec_unpacker.sv
module tb_tx_vec_unpacker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [19:0] cfg_lo = '0, cfg_hi = '0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready, bit_valid, bit_data, bit_last;
    logic        bit_ready = 1'b1;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit bp_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural model
    logic [9:0] m_cfg [4];
    bit         m_q [$];
    bit         m_busy = 0;
    int         m_acc = 0;

    always #4 clk = ~clk;

    tx_vec_unpacker dut (.*);

    function automatic logic [9:0] mk(input bit stop, input int len, input bit dir, input int start);
        return {stop, 3'(len), dir, 5'(start)};
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            if (m_busy) begin
                if (bit_ready) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) m_busy = 0;
                end
            end else if (word_valid) begin
                for (int v = 0; v < 4; v++) begin
                    for (int k = 0; k <= int'(m_cfg[v][8:6]); k++) begin
                        int idx;
                        idx = m_cfg[v][5] ? (int'(m_cfg[v][4:0]) - k) : (int'(m_cfg[v][4:0]) + k);
                        m_q.push_back(word_data[idx & 31]);
                    end
                    if (m_cfg[v][9]) break;
                end
                m_busy = 1;
                m_acc++;
            end
            if (cfg_we) begin
                m_cfg[0] = cfg_lo[9:0];  m_cfg[1] = cfg_lo[19:10];
                m_cfg[2] = cfg_hi[9:0];  m_cfg[3] = cfg_hi[19:10];
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(word_ready == !m_busy, "R8", "word_ready", word_ready, !m_busy);
            check(bit_valid == m_busy, "R8", "bit_valid", bit_valid, m_busy);
            if (m_busy && bit_valid) begin
                check(bit_data == m_q[0], cur_req, "bit_data", bit_data, m_q[0]);
                check(bit_last == (m_q.size() == 1), "R9", "bit_last", bit_last, m_q.size() == 1);
            end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bit_ready = bp_mode ? lfsr[0] : 1'b1;
    end

    task automatic load_cfg(input logic [9:0] v0, v1, v2, v3);
        @(negedge clk);
        cfg_lo = {v1, v0}; cfg_hi = {v3, v2}; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] d);
        int n;
        @(negedge clk);
        n = m_acc;
        word_valid = 1'b1; word_data = d;
        do begin @(posedge clk); #1; end while (m_acc == n);
        word_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do begin @(posedge clk); #1; end while (m_busy);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_cfg[i] = mk(i == 3, 7, 0, i * 8);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(word_ready == 1'b1, "R1", "reset word_ready", word_ready, 1);
        check(bit_valid == 1'b0, "R1", "reset bit_valid", bit_valid, 0);

        // R1: default packing, 4 x 8 LSB-first
        cur_req = "R1";
        send(32'hA5C3_0F96); send(32'h1234_5678); wait_idle();

        // R2 R4: 7-bit characters, MSB-first
        cur_req = "R4";
        load_cfg(mk(0,6,1,6), mk(0,6,1,14), mk(0,6,1,22), mk(1,6,1,30));
        send(32'hDEAD_BEEF); send(32'h0F0F_F0F0); wait_idle();

        // R3: 15-bit characters, LSB-first, runs of 8 and 7
        cur_req = "R3";
        load_cfg(mk(0,7,0,0), mk(0,6,0,8), mk(0,7,0,16), mk(1,6,0,24));
        send(32'h8001_7FFE); send(32'hC33C_5AA5); wait_idle();

        // R5: 23-bit MSB-first, stop on vector 2, vector 3 nonzero but unused
        cur_req = "R5";
        load_cfg(mk(0,7,1,22), mk(0,7,1,14), mk(1,6,1,6), mk(1,7,0,31));
        send(32'hFFC0_0001); send(32'h7654_3210); wait_idle();
        // R5: stop on vector 0 yields a single short run
        load_cfg(mk(1,2,0,29), mk(0,7,0,0), mk(0,7,0,8), mk(1,7,0,16));
        send(32'hE000_0000); send(32'h4000_0000); wait_idle();

        // R6: no stop flag anywhere, vector 3 ends the word
        cur_req = "R6";
        load_cfg(mk(0,1,0,0), mk(0,0,1,9), mk(0,3,1,20), mk(0,4,0,27));
        send(32'h9ABC_DEF1); send(32'h0800_0201); wait_idle();

        // R4: index wraps below 0 and above 31
        cur_req = "R4";
        load_cfg(mk(0,7,1,2), mk(1,7,0,29), mk(0,0,0,0), mk(0,0,0,0));
        send(32'h8000_0005); send(32'h6000_0003); wait_idle();

        // R7: random backpressure, back-to-back words
        cur_req = "R7";
        bp_mode = 1;
        load_cfg(mk(0,6,1,6), mk(0,6,1,14), mk(0,6,1,22), mk(1,6,1,30));
        for (int i = 0; i < 12; i++) send(32'h1357_9BDF * (i + 3));
        wait_idle();
        bp_mode = 0;

        // R10: write in the middle of a word, then in the same cycle as acceptance
        cur_req = "R10";
        send(32'hCAFE_F00D);
        repeat (5) @(negedge clk);
        cfg_lo = {mk(0,7,0,8), mk(0,7,0,0)}; cfg_hi = {mk(1,7,0,24), mk(0,7,0,16)}; cfg_we = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
        wait_idle();
        send(32'hCAFE_F00D); wait_idle();
        @(negedge clk);
        cfg_lo = {mk(0,0,0,0), mk(1,3,1,31)}; cfg_hi = {mk(0,0,0,0), mk(0,0,0,0)}; cfg_we = 1'b1;
        word_valid = 1'b1; word_data = 32'h55AA_33CC;
        @(negedge clk); cfg_we = 1'b0; word_valid = 1'b0;
        wait_idle();
        send(32'hF000_0000); wait_idle();

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule